// File: doc/BRIEF.md
# Endian-Configurable Load/Store Lane Unit

This unit sits between a 32-bit datapath and a byte-addressable data memory port that is one word wide. On the store side it receives a byte address, an access size, the operand to be written and a static endianness select. It returns the word-aligned memory address, one write enable per byte lane and a write word that already has the operand bytes placed in the right lanes. On the load side it receives the word the memory returned and extracts the addressed bytes. It orders them for the selected endianness and widens the result to 32 bits with either zero or sign extension.

Accesses can be 8, 16 or 32 bits wide. A word access must start on an address whose two low bits are zero, and a half-word access on an even address. An access that breaks its alignment rule raises a flag, and the unit then drives no write enables and returns zero as load data. The unit is purely combinational and has no state.

Byte lane k of the memory word (bits 8k+7..8k) always holds the byte at address base+k, where base is the memory address output. Endianness decides which operand byte goes to which lane. For the word 0x11223344 at address 100, big-endian order puts 0x11 in byte 100 and 0x44 in byte 103. Little-endian order does the opposite.

Top module: `lsu_lane_unit`

## Requirements
- R1: The memory address output equals the byte address with its two least significant bits forced to zero.
- R2: The size codes are 0 = byte, 1 = half-word, 2 = word, and 3 behaves exactly as word. The misalign flag is set for a word whose address bits [1:0] are not 00 and for a half-word whose address bit 0 is 1. A byte access never sets it.
- R3: While the misalign flag is set, all four byte enables are 0 and the load data output is 0.
- R4: For an aligned store, the byte enables are 0001 shifted left by the offset for a byte, 0011 shifted left by the offset for a half-word, and 1111 for a word. The offset is address bits [1:0] and enable bit k controls lane k (bits 8k+7..8k).
- R5: For a store of n bytes at byte address A, little-endian order places operand byte j (bits 8j+7..8j) at address A+j. Big-endian order places it at A+n-1-j.
- R6: The write data does not depend on address bits [1:0]. A byte operand is copied into all four lanes, and a half-word pattern is copied into both halves. The word 0x11223344 gives 0x44332211 in big-endian mode and 0x11223344 in little-endian mode.
- R7: A load of n bytes at address A assembles its value from lanes A..A+n-1 using the same byte-to-address rule as R5. An aligned little-endian word load returns the memory word unchanged.
- R8: After the word 0x11223344 has been written in a given mode, a byte load from its base address returns 0x11 in big-endian mode and 0x44 in little-endian mode.
- R9: When the unsigned select is 1, byte and half-word loads are zero-extended. When it is 0, they are sign-extended from bit 7 or bit 15. Word loads ignore the select.
- R10: When the store request is 0, the byte enables are 0000. The load data does not depend on the store request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_addr | input | ADDR_W | Byte address of the access |
| i_size | input | 2 | Access size code (0 byte, 1 half-word, 2 or 3 word) |
| i_big_end | input | 1 | 1 selects big-endian byte order, 0 selects little-endian |
| i_unsigned | input | 1 | 1 zero-extends narrow loads, 0 sign-extends them |
| i_store | input | 1 | 1 requests a write this cycle |
| i_wdata | input | 32 | Store operand, right-justified |
| i_rdata | input | 32 | Word returned by the memory |
| o_maddr | output | ADDR_W | Word-aligned memory address |
| o_be | output | 4 | Per-lane write enables |
| o_wdata | output | 32 | Lane-steered write word |
| o_rdata | output | 32 | Extracted and extended load value |
| o_misalign | output | 1 | Access breaks its alignment rule |

## Verification
The store steering and the load extraction are decoded from the same address and size in the same cycle. The bench therefore drives a store operand and an unrelated memory word together, toggles the store request on the same vector, and judges the write enables, the write word and the load value against a byte-array model at the same step. A misaligned access can also coincide with a store request. The bench provokes this on every size and offset pair and expects silent enables and zero load data, while the address output still follows R1.

// File: rtl/lsu_pkg.sv
// Package: shared constants and size encoding for the load/store lane unit.
// Assumes a word of LANES byte lanes, each LANE_W bits wide.
package lsu_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = LANE_W * LANES;
    localparam int HALF_W  = 2 * LANE_W;
    localparam int OFF_W   = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD3 = 2'd3
    } lsu_size_e;
endpackage

// File: rtl/lsu_align_chk.sv
// Module: alignment check and byte-enable generation.
// Assumes the offset is the low address bits and lane k maps to address base+k.
module lsu_align_chk
    import lsu_pkg::*;
(
    input  logic [OFF_W-1:0] i_off,
    input  logic [1:0]       i_size,
    input  logic             i_store,
    output logic             o_misalign,
    output logic [LANES-1:0] o_be
);
    logic [LANES-1:0] span;

    // Detect an access that breaks its size's alignment rule.
    always_comb begin
        unique case (lsu_size_e'(i_size))
            SZ_BYTE: o_misalign = 1'b0;
            SZ_HALF: o_misalign = i_off[0];
            default: o_misalign = |i_off;
        endcase
    end

    // Base lane mask for the access width.
    always_comb begin
        unique case (lsu_size_e'(i_size))
            SZ_BYTE: span = LANES'(1);
            SZ_HALF: span = LANES'(3);
            default: span = {LANES{1'b1}};
        endcase
    end

    // Shift the mask to the addressed lanes, gated by request and alignment.
    always_comb begin
        if (i_store && !o_misalign) o_be = span << i_off;
        else                        o_be = '0;
    end
endmodule

// File: rtl/lsu_store_steer.sv
// Module: places the store operand into byte lanes for the selected order.
// Assumes the operand is right-justified; output does not depend on offset.
module lsu_store_steer
    import lsu_pkg::*;
(
    input  logic [1:0]        i_size,
    input  logic              i_big_end,
    input  logic [WORD_W-1:0] i_wdata,
    output logic [WORD_W-1:0] o_wdata
);
    logic [WORD_W-1:0] swapped;
    logic [HALF_W-1:0] half_ord;

    // Reverse the byte order of the full word, one lane per iteration.
    for (genvar k = 0; k < LANES; k++) begin : g_swap
        assign swapped[k*LANE_W +: LANE_W] = i_wdata[(LANES-1-k)*LANE_W +: LANE_W];
    end

    // Order the two half-word bytes for the selected endianness.
    always_comb begin
        if (i_big_end) half_ord = {i_wdata[LANE_W-1:0], i_wdata[HALF_W-1:LANE_W]};
        else           half_ord = i_wdata[HALF_W-1:0];
    end

    // Replicate the ordered pattern across the whole word.
    always_comb begin
        unique case (lsu_size_e'(i_size))
            SZ_BYTE: o_wdata = {LANES{i_wdata[LANE_W-1:0]}};
            SZ_HALF: o_wdata = {(LANES/2){half_ord}};
            default: o_wdata = i_big_end ? swapped : i_wdata;
        endcase
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Module: pulls the addressed bytes out of the memory word and extends them.
// Assumes the misalign flag comes from the alignment check of the same access.
module lsu_load_extract
    import lsu_pkg::*;
(
    input  logic [WORD_W-1:0] i_rdata,
    input  logic [OFF_W-1:0]  i_off,
    input  logic [1:0]        i_size,
    input  logic              i_big_end,
    input  logic              i_unsigned,
    input  logic              i_misalign,
    output logic [WORD_W-1:0] o_rdata
);
    logic [WORD_W-1:0] swapped;
    logic [LANE_W-1:0] byte_v;
    logic [LANE_W-1:0] lo_lane;
    logic [LANE_W-1:0] hi_lane;
    logic [HALF_W-1:0] half_v;
    logic [4:0]        byte_idx;
    logic [4:0]        half_idx;

    // Reverse the memory word for big-endian word loads.
    for (genvar k = 0; k < LANES; k++) begin : g_swap
        assign swapped[k*LANE_W +: LANE_W] = i_rdata[(LANES-1-k)*LANE_W +: LANE_W];
    end

    // Bit positions of the addressed byte and of the addressed half-word pair.
    assign byte_idx = {i_off, 3'b000};
    assign half_idx = {i_off[1], 4'b0000};

    // Select the addressed lanes.
    always_comb begin
        byte_v  = i_rdata[byte_idx +: LANE_W];
        lo_lane = i_rdata[half_idx +: LANE_W];
        hi_lane = i_rdata[(half_idx + 5'd8) +: LANE_W];
        half_v  = i_big_end ? {lo_lane, hi_lane} : {hi_lane, lo_lane};
    end

    // Extend to the full word, or return zero on a misaligned access.
    always_comb begin
        if (i_misalign) begin
            o_rdata = '0;
        end else begin
            unique case (lsu_size_e'(i_size))
                SZ_BYTE: o_rdata = {{(WORD_W-LANE_W){~i_unsigned & byte_v[LANE_W-1]}}, byte_v};
                SZ_HALF: o_rdata = {{(WORD_W-HALF_W){~i_unsigned & half_v[HALF_W-1]}}, half_v};
                default: o_rdata = i_big_end ? swapped : i_rdata;
            endcase
        end
    end
endmodule

// File: rtl/lsu_lane_unit.sv
// Module: top of the load/store lane unit; combinational, no state.
// Assumes a byte-addressable memory port one word wide, lane k at base+k.
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] i_addr,
    input  logic [1:0]        i_size,
    input  logic              i_big_end,
    input  logic              i_unsigned,
    input  logic              i_store,
    input  logic [WORD_W-1:0] i_wdata,
    input  logic [WORD_W-1:0] i_rdata,
    output logic [ADDR_W-1:0] o_maddr,
    output logic [LANES-1:0]  o_be,
    output logic [WORD_W-1:0] o_wdata,
    output logic [WORD_W-1:0] o_rdata,
    output logic              o_misalign
);
    logic [OFF_W-1:0] off;
    logic             misalign;

    // Split the address into word address and lane offset.
    assign off     = i_addr[OFF_W-1:0];
    assign o_maddr = {i_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign o_misalign = misalign;

    lsu_align_chk u_align (
        .i_off      (off),
        .i_size     (i_size),
        .i_store    (i_store),
        .o_misalign (misalign),
        .o_be       (o_be)
    );

    lsu_store_steer u_steer (
        .i_size    (i_size),
        .i_big_end (i_big_end),
        .i_wdata   (i_wdata),
        .o_wdata   (o_wdata)
    );

    lsu_load_extract u_extract (
        .i_rdata    (i_rdata),
        .i_off      (off),
        .i_size     (i_size),
        .i_big_end  (i_big_end),
        .i_unsigned (i_unsigned),
        .i_misalign (misalign),
        .o_rdata    (o_rdata)
    );
endmodule

// File: rtl/lsu_lane_unit_chk.sv
// Module: assertion checker for the lane unit, bound to every instance.
// Assumes combinational outputs; checks are immediate and run on every change.
module lsu_lane_unit_chk
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic [ADDR_W-1:0] i_addr,
    input logic [1:0]        i_size,
    input logic              i_big_end,
    input logic              i_unsigned,
    input logic              i_store,
    input logic [WORD_W-1:0] i_wdata,
    input logic [WORD_W-1:0] i_rdata,
    input logic [ADDR_W-1:0] o_maddr,
    input logic [LANES-1:0]  o_be,
    input logic [WORD_W-1:0] o_wdata,
    input logic [WORD_W-1:0] o_rdata,
    input logic              o_misalign
);
    // Relate outputs to inputs whenever any of them changes.
    always_comb begin
        assert_maddr_R1: assert (o_maddr[OFF_W-1:0] == '0 &&
                                 o_maddr[ADDR_W-1:OFF_W] == i_addr[ADDR_W-1:OFF_W]);
        if (i_size == 2'd0)
            assert_byte_aligned_R2: assert (!o_misalign);
        if (o_misalign)
            assert_misalign_quiet_R3: assert (o_be == '0 && o_rdata == '0);
        assert_be_count_R4: assert (o_be == '0 || $countones(o_be) == 1 ||
                                    $countones(o_be) == 2 || $countones(o_be) == 4);
        if (i_size == 2'd0)
            assert_byte_replicated_R6: assert (o_wdata == {LANES{i_wdata[LANE_W-1:0]}});
        if (i_size[1] && !i_big_end && !o_misalign)
            assert_le_word_load_R7: assert (o_rdata == i_rdata);
        if (i_unsigned && i_size == 2'd0)
            assert_zero_ext_R9: assert (o_rdata[WORD_W-1:LANE_W] == '0);
        if (!i_store)
            assert_be_idle_R10: assert (o_be == '0);
    end
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_lsu_lane_unit.sv
// Bench: byte-array reference model compared against the lane unit each clock.
module test_lsu_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size = '0;
    logic        big = 1'b0;
    logic        uns = 1'b0;
    logic        store = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata = '0;
    logic [31:0] maddr;
    logic [3:0]  be;
    logic [31:0] wout;
    logic [31:0] rout;
    logic        mis;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    lsu_lane_unit i_lsu_lane_unit (
        .i_addr(addr), .i_size(size), .i_big_end(big), .i_unsigned(uns),
        .i_store(store), .i_wdata(wdata), .i_rdata(rdata),
        .o_maddr(maddr), .o_be(be), .o_wdata(wout), .o_rdata(rout),
        .o_misalign(mis)
    );

    // Compare one value and count it.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access after a rising edge.
    task automatic drive(input logic [31:0] a, input logic [1:0] s, input logic b,
                         input logic u, input logic st, input logic [31:0] wd,
                         input logic [31:0] rd);
        @(posedge clk);
        #2;
        addr = a; size = s; big = b; uns = u; store = st; wdata = wd; rdata = rd;
    endtask

    // Reference model: byte array view of the memory word, checked at the falling edge.
    task automatic model_check();
        int          nb;
        int          off;
        bit          exp_mis;
        logic [3:0]  exp_be;
        logic [7:0]  lane [4];
        logic [31:0] exp_w;
        logic [31:0] exp_r;
        nb  = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        off = int'(addr[1:0]);
        exp_mis = (off % nb) != 0;
        exp_be = '0;
        for (int k = 0; k < 4; k++)
            if (store && !exp_mis && k >= off && k < off + nb) exp_be[k] = 1'b1;
        for (int slot = 0; slot < 4; slot += nb)
            for (int j = 0; j < nb; j++)
                lane[slot + (big ? nb - 1 - j : j)] = wdata[8*j +: 8];
        exp_w = {lane[3], lane[2], lane[1], lane[0]};
        exp_r = '0;
        if (!exp_mis) begin
            for (int j = 0; j < nb; j++)
                exp_r[8*j +: 8] = rdata[8*(off + (big ? nb - 1 - j : j)) +: 8];
            if (!uns && nb < 4 && exp_r[8*nb-1])
                for (int b2 = 8*nb; b2 < 32; b2++) exp_r[b2] = 1'b1;
        end
        @(negedge clk);
        check("R1 maddr", maddr, {addr[31:2], 2'b00});
        check("R2 misalign", {31'd0, mis}, {31'd0, exp_mis});
        check("R4 byte enables (R3 when misaligned, R10 when idle)", {28'd0, be}, {28'd0, exp_be});
        check("R5 R6 write lanes", wout, exp_w);
        check("R7 R9 load value (R3 when misaligned)", rout, exp_r);
    endtask

    initial begin
        logic [31:0] stored;
        // Reset state: all inputs quiet.
        repeat (3) @(negedge clk);
        check("R10 reset enables", {28'd0, be}, 32'd0);
        check("R10 reset load data", rout, 32'd0);
        check("R2 reset misalign", {31'd0, mis}, 32'd0);
        rst_n = 1'b1;

        // R6 / R8: the example word in both orders.
        drive(32'd100, 2'd2, 1'b1, 1'b0, 1'b1, 32'h11223344, 32'h0);
        @(negedge clk); stored = wout;
        check("R6 big-endian word image", wout, 32'h44332211);
        drive(32'd100, 2'd0, 1'b1, 1'b1, 1'b0, 32'h0, stored);
        @(negedge clk);
        check("R8 big-endian byte at base", rout, 32'h11);
        drive(32'd100, 2'd2, 1'b0, 1'b0, 1'b1, 32'h11223344, 32'h0);
        @(negedge clk); stored = wout;
        check("R6 little-endian word image", wout, 32'h11223344);
        drive(32'd100, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0, stored);
        @(negedge clk);
        check("R8 little-endian byte at base", rout, 32'h44);

        // R9: sign versus zero extension of a negative half-word.
        drive(32'd2, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h8001_0000);
        @(negedge clk);
        check("R9 signed half", rout, 32'hFFFF_8001);
        drive(32'd2, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0, 32'h8001_0000);
        @(negedge clk);
        check("R9 unsigned half", rout, 32'h0000_8001);

        // R10: load data unchanged by toggling the store request.
        drive(32'd1, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0000_9A00);
        @(negedge clk); stored = rout;
        drive(32'd1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0000_9A00);
        @(negedge clk);
        check("R10 load independent of store", rout, stored);

        // Every size, offset, order, extension and request combination.
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                for (int e = 0; e < 2; e++)
                    for (int u = 0; u < 2; u++)
                        for (int st = 0; st < 2; st++) begin
                            drive({$urandom} & 32'hFFFF_FFFC | 32'(o), 2'(s), 1'(e), 1'(u),
                                  1'(st), $urandom, $urandom);
                            model_check();
                        end

        // Random mixes.
        for (int i = 0; i < 400; i++) begin
            drive($urandom, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  $urandom, $urandom);
            model_check();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule